// File: doc/BRIEF.md
# Bus Watch Trigger Unit

This unit observes a processor bus without taking part in it. Each cycle it sees a 16-bit address, an 8-bit data value, a write flag and a strobe that marks cycles that really move data. It compares what it sees against two programmed comparators, A and B, under a selectable condition. When the condition is met it raises a single-cycle trigger pulse, which a capture engine elsewhere on the chip can use to start or stop recording. It fires once and then stays quiet until software writes the control register again. Comparator A always holds an address. Comparator B holds either a second address or, in the data modes, an 8-bit data pattern in its low byte.

Apart from the trigger, each comparator can drive a breakpoint output of its own. This output flags every valid access to the comparator's address, whatever the trigger mode and one-shot state are. A halt controller would use it to stop the processor.

Software programs the unit through a narrow register write port with three registers: comparator A, comparator B and control.

Top module: `bus_watch_trigger`

## Requirements
- R1: After reset both outputs are low, both comparators are zero, and control is zero (mode 0, trigger disabled, both breakpoints disabled).
- R2: A cycle with `bus_valid` low never produces a trigger or a breakpoint, whatever its address and data are.
- R3: Mode 0 (address A) triggers on a valid read or write whose address equals comparator A.
- R4: Mode 1 (A or B) triggers on a valid read or write whose address equals comparator A or comparator B.
- R5: Mode 2 (window) triggers on a valid write whose address lies in the range from A to B inclusive. Reads never trigger in this mode.
- R6: Mode 3 (data equal) triggers on a valid write to address A whose data equals the low 8 bits of comparator B.
- R7: Mode 4 (data differs) triggers on a valid write to address A whose data differs from the low 8 bits of comparator B.
- R8: Mode 5 (arm then B) starts disarmed. A valid access at address A arms it. A valid access at address B triggers only if the unit was armed before that cycle, so an access matching both A and B arms the unit but does not fire.
- R9: Any write to the control register clears the armed state, including a write that re-enables the unit.
- R10: `trig_pulse` goes high for exactly one cycle, on the clock edge that samples the matching bus cycle. After it fires, no further trigger occurs until the control register is written. With the enable bit (control bit 3) low, or in the unused modes 6 and 7, no trigger occurs.
- R11: `brk_hit` goes high on the edge that samples a valid access whose address equals comparator A with control bit 4 set, or equals comparator B with control bit 5 set. It does so on every such access, regardless of enable, mode or one-shot state.
- R12: Register select 0 writes comparator A and select 1 writes comparator B. Select 2 writes control, with mode in bits 2:0. Select 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| bus_valid | input | 1 | Bus cycle carries a real transfer |
| bus_write | input | 1 | Bus cycle is a write |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 8 | Bus data |
| trig_pulse | output | 1 | Single-cycle trigger |
| brk_hit | output | 1 | Breakpoint match |

## Verification
The bench sweeps every mode against addresses just inside and just outside the A..B window, both access directions, and matching and non-matching data.

- A window compare that is off by one would miss A or B, or would include the neighbours A-1 and B+1.
- The data modes are driven with reads to address A. A design that forgot the write qualifier would fire on them.
- In the arm-then-B mode, the bench checks B before A, A followed by B, and re-arming after control writes. A design that armed and fired in the same cycle would fire too early. A design that kept the armed state across a control rewrite would fire without a fresh A access.
- The bench also checks the one-shot lock, disabled operation and invalid cycles. A breakpoint wrongly gated by the trigger enable would go silent in those checks.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

  typedef enum logic [2:0] {
    M_ADDR_A     = 3'd0,
    M_ADDR_AB    = 3'd1,
    M_RANGE_WR   = 3'd2,
    M_WR_DATA_EQ = 3'd3,
    M_WR_DATA_NE = 3'd4,
    M_ARM_THEN_B = 3'd5,
    M_RSVD6      = 3'd6,
    M_RSVD7      = 3'd7
  } trig_mode_e;

  typedef struct packed {
    trig_mode_e mode;
    logic       en;
    logic       brk_a;
    logic       brk_b;
  } ctl_t;

  localparam logic [1:0] SEL_CMP_A = 2'd0;
  localparam logic [1:0] SEL_CMP_B = 2'd1;
  localparam logic [1:0] SEL_CTL   = 2'd2;

  // control field positions inside the write word
  localparam int CTL_MODE_LSB = 0;
  localparam int CTL_EN_BIT   = 3;
  localparam int CTL_BRKA_BIT = 4;
  localparam int CTL_BRKB_BIT = 5;

endpackage

// File: rtl/bwt_cfg.sv
module bwt_cfg
  import bwt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cmp_a,
  output logic [ADDR_W-1:0] cmp_b,
  output ctl_t              ctl,
  output logic              ctl_wr
);

  ctl_t ctl_next;

  assign ctl_wr = cfg_we && (cfg_sel == SEL_CTL);

  always_comb begin
    ctl_next.mode  = trig_mode_e'(cfg_wdata[CTL_MODE_LSB +: 3]);
    ctl_next.en    = cfg_wdata[CTL_EN_BIT];
    ctl_next.brk_a = cfg_wdata[CTL_BRKA_BIT];
    ctl_next.brk_b = cfg_wdata[CTL_BRKB_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a <= '0;
      cmp_b <= '0;
      ctl   <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_CMP_A: cmp_a <= cfg_wdata;
        SEL_CMP_B: cmp_b <= cfg_wdata;
        SEL_CTL:   ctl   <= ctl_next;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/bwt_match.sv
module bwt_match
  import bwt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [ADDR_W-1:0] cmp_a,
  input  logic [ADDR_W-1:0] cmp_b,
  input  trig_mode_e        mode,
  output logic              hit_a,
  output logic              hit_b,
  output logic              in_win,
  output logic              data_eq,
  output logic              cond_hit,
  output logic              arm_evt,
  output logic              b_evt
);

  function automatic logic addr_eq(input logic [ADDR_W-1:0] x,
                                   input logic [ADDR_W-1:0] y);
    return x == y;
  endfunction

  function automatic logic inside_window(input logic [ADDR_W-1:0] x,
                                         input logic [ADDR_W-1:0] lo,
                                         input logic [ADDR_W-1:0] hi);
    return (x >= lo) && (x <= hi);
  endfunction

  assign hit_a   = addr_eq(bus_addr, cmp_a);
  assign hit_b   = addr_eq(bus_addr, cmp_b);
  assign in_win  = inside_window(bus_addr, cmp_a, cmp_b);
  assign data_eq = (bus_data == cmp_b[DATA_W-1:0]);
  assign arm_evt = bus_valid && hit_a;
  assign b_evt   = bus_valid && hit_b;

  // condition for every mode except the sequenced one
  always_comb begin
    cond_hit = 1'b0;
    if (bus_valid) begin
      case (mode)
        M_ADDR_A:     cond_hit = hit_a;
        M_ADDR_AB:    cond_hit = hit_a || hit_b;
        M_RANGE_WR:   cond_hit = bus_write && in_win;
        M_WR_DATA_EQ: cond_hit = bus_write && hit_a && data_eq;
        M_WR_DATA_NE: cond_hit = bus_write && hit_a && !data_eq;
        default:      cond_hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/bwt_seq.sv
module bwt_seq
  import bwt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic       en,
  input  trig_mode_e mode,
  input  logic       cond_hit,
  input  logic       arm_evt,
  input  logic       b_evt,
  output logic       fire,
  output logic       armed,
  output logic       done,
  output logic       trig_pulse
);

  logic seq_mode;

  assign seq_mode = (mode == M_ARM_THEN_B);
  assign fire     = en && !done && (seq_mode ? (armed && b_evt) : cond_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      done       <= 1'b0;
      trig_pulse <= 1'b0;
    end else begin
      trig_pulse <= fire;
      if (ctl_wr) begin
        armed <= 1'b0;
        done  <= 1'b0;
      end else begin
        armed <= armed || (en && seq_mode && arm_evt);
        done  <= done || fire;
      end
    end
  end

endmodule

// File: rtl/bus_watch_trigger.sv
module bus_watch_trigger
  import bwt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              trig_pulse,
  output logic              brk_hit
);

  logic [ADDR_W-1:0] cmp_a, cmp_b;
  ctl_t              ctl_q;
  logic              ctl_wr;
  logic              hit_a, hit_b, in_win, data_eq, cond_hit, arm_evt, b_evt;
  logic              fire, armed, done;
  logic              brk_next;
  trig_mode_e        mode_w;
  logic              en_w, brk_a_w, brk_b_w;

  assign mode_w  = ctl_q.mode;
  assign en_w    = ctl_q.en;
  assign brk_a_w = ctl_q.brk_a;
  assign brk_b_w = ctl_q.brk_b;

  bwt_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .ctl(ctl_q), .ctl_wr(ctl_wr)
  );

  bwt_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_data(bus_data), .cmp_a(cmp_a), .cmp_b(cmp_b), .mode(mode_w),
    .hit_a(hit_a), .hit_b(hit_b), .in_win(in_win), .data_eq(data_eq),
    .cond_hit(cond_hit), .arm_evt(arm_evt), .b_evt(b_evt)
  );

  bwt_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .en(en_w), .mode(mode_w),
    .cond_hit(cond_hit), .arm_evt(arm_evt), .b_evt(b_evt),
    .fire(fire), .armed(armed), .done(done), .trig_pulse(trig_pulse)
  );

  // breakpoints bypass enable, mode and one-shot lock
  assign brk_next = bus_valid && ((brk_a_w && hit_a) || (brk_b_w && hit_b));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_hit <= 1'b0;
    else        brk_hit <= brk_next;
  end

endmodule

// File: rtl/bwt_checker.sv
module bwt_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [ADDR_W-1:0] cmp_a,
  input logic [2:0]        mode,
  input logic              en,
  input logic              brk_a_en,
  input logic              armed,
  input logic              done,
  input logic              ctl_wr,
  input logic              trig_pulse,
  input logic              brk_hit
);

  // R2
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (!trig_pulse && !brk_hit));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !trig_pulse);

  // R10
  oneshot_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctl_wr) |=> !trig_pulse);

  // R5
  range_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && !bus_write) |=> !trig_pulse);

  // R6
  data_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd3 || mode == 3'd4) && !bus_write) |=> !trig_pulse);

  // R8
  seq_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && !armed) |=> !trig_pulse);

  // R9
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !armed);

  // R11
  brk_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && brk_a_en && bus_addr == cmp_a) |=> brk_hit);

endmodule

bind bus_watch_trigger bwt_checker #(.ADDR_W(ADDR_W)) u_bwt_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .cmp_a(cmp_a), .mode(mode_w), .en(en_w),
  .brk_a_en(brk_a_w), .armed(armed), .done(done), .ctl_wr(ctl_wr),
  .trig_pulse(trig_pulse), .brk_hit(brk_hit)
);

// File: tb/test_bus_watch_trigger.sv
module test_bus_watch_trigger;

  localparam int A_VAL = 16'h1230;
  localparam int B_VAL = 16'h1238;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        trig_pulse, brk_hit;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  bus_watch_trigger i_bus_watch_trigger (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .trig_pulse(trig_pulse), .brk_hit(brk_hit)
  );

  task automatic check(input logic act, input logic exp, input string req,
                       input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_ctl(input int mode, input bit en, input bit ba, input bit bb);
    wr_cfg(2'd2, 16'((mode & 7) | (int'(en) << 3) | (int'(ba) << 4) | (int'(bb) << 5)));
  endtask

  // drive one bus cycle; on return outputs show the registered result
  task automatic bus(input bit v, input bit w, input int a, input int d);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = 16'(a); bus_data = 8'(d);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  function automatic bit model_trig(int m, bit w, int a, int d);
    int lo_byte;
    lo_byte = B_VAL % 256;
    if (m == 0) return a == A_VAL;
    if (m == 1) return (a == A_VAL) || (a == B_VAL);
    if (m == 2) return w && !(a < A_VAL) && !(a > B_VAL);
    if (m == 3) return w && (a == A_VAL) && (d == lo_byte);
    if (m == 4) return w && (a == A_VAL) && (d != lo_byte);
    return 1'b0;
  endfunction

  function automatic string req_of(int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int addrs [6];
    int datas [3];
    addrs = '{16'h122F, 16'h1230, 16'h1234, 16'h1238, 16'h1239, 16'hFFFF};
    datas = '{8'h38, 8'h37, 8'h00};

    repeat (3) @(negedge clk);
    check(trig_pulse, 1'b0, "R1", "trig in reset");
    check(brk_hit, 1'b0, "R1", "brk in reset");
    rst_n = 1'b1;

    // R1: zero config -> A=0, disabled, breakpoints off
    bus(1, 1, 0, 0);
    check(trig_pulse, 1'b0, "R1", "disabled after reset");
    check(brk_hit, 1'b0, "R1", "brk off after reset");

    // R12: select 3 ignored, then enable mode 0 with A still zero
    wr_cfg(2'd3, 16'hFFFF);
    set_ctl(0, 1, 1, 0);
    bus(1, 0, 0, 0);
    check(trig_pulse, 1'b1, "R12", "sel3 left A at zero");
    check(brk_hit, 1'b1, "R12", "brk at A zero");

    wr_cfg(2'd0, 16'(A_VAL));
    wr_cfg(2'd1, 16'(B_VAL));

    // sweep of all modes
    for (int m = 0; m < 8; m++) begin
      for (int ai = 0; ai < 6; ai++) begin
        for (int w = 0; w < 2; w++) begin
          for (int di = 0; di < 3; di++) begin
            set_ctl(m, 1, 1, 0);
            bus(1, w[0], addrs[ai], datas[di]);
            check(trig_pulse, model_trig(m, w[0], addrs[ai], datas[di]),
                  req_of(m), $sformatf("mode %0d addr %h w %0d d %h",
                  m, addrs[ai], w, datas[di]));
            check(brk_hit, addrs[ai] == A_VAL, "R11",
                  $sformatf("brk A addr %h", addrs[ai]));
          end
        end
      end
    end

    // R2: invalid cycles quiet
    set_ctl(0, 1, 1, 1);
    bus(0, 1, A_VAL, 8'h38);
    check(trig_pulse, 1'b0, "R2", "invalid trig");
    check(brk_hit, 1'b0, "R2", "invalid brk");

    // R10: one-shot and single-cycle width
    bus(1, 0, A_VAL, 0);
    check(trig_pulse, 1'b1, "R10", "first match");
    @(negedge clk);
    check(trig_pulse, 1'b0, "R10", "pulse one cycle");
    bus(1, 0, A_VAL, 0);
    check(trig_pulse, 1'b0, "R10", "second match locked");
    check(brk_hit, 1'b1, "R11", "brk ignores lock");
    bus(1, 1, B_VAL, 0);
    check(brk_hit, 1'b1, "R11", "brk B enabled");
    set_ctl(0, 1, 1, 1);
    bus(1, 0, A_VAL, 0);
    check(trig_pulse, 1'b1, "R10", "rearm by ctl write");

    // R10/R11: disabled trigger, breakpoint still live
    set_ctl(0, 0, 1, 0);
    bus(1, 0, A_VAL, 0);
    check(trig_pulse, 1'b0, "R10", "disabled");
    check(brk_hit, 1'b1, "R11", "brk while disabled");
    bus(1, 0, B_VAL, 0);
    check(brk_hit, 1'b0, "R11", "brk B disabled");

    // R8: sequenced mode
    set_ctl(5, 1, 0, 0);
    bus(1, 0, B_VAL, 0);
    check(trig_pulse, 1'b0, "R8", "B before A");
    bus(1, 0, A_VAL, 0);
    check(trig_pulse, 1'b0, "R8", "A arms only");
    bus(1, 1, 16'h4000, 0);
    check(trig_pulse, 1'b0, "R8", "other addr");
    bus(1, 1, B_VAL, 0);
    check(trig_pulse, 1'b1, "R8", "B after A");
    bus(1, 1, B_VAL, 0);
    check(trig_pulse, 1'b0, "R10", "seq one-shot");

    // R9: control rewrite disarms
    set_ctl(5, 1, 0, 0);
    bus(1, 0, A_VAL, 0);
    set_ctl(5, 1, 0, 0);
    bus(1, 0, B_VAL, 0);
    check(trig_pulse, 1'b0, "R9", "disarmed by rewrite");
    bus(1, 0, A_VAL, 0);
    set_ctl(5, 0, 0, 0);
    set_ctl(5, 1, 0, 0);
    bus(1, 0, B_VAL, 0);
    check(trig_pulse, 1'b0, "R9", "disarmed by re-enable");

    // R8: A equal to B arms first, fires second
    wr_cfg(2'd1, 16'(A_VAL));
    set_ctl(5, 1, 0, 0);
    bus(1, 0, A_VAL, 0);
    check(trig_pulse, 1'b0, "R8", "A==B first access");
    bus(1, 0, A_VAL, 0);
    check(trig_pulse, 1'b1, "R8", "A==B second access");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule